// File: doc/BRIEF.md
# One-shot triggered pulse timer

An up-counting timer with a single compare channel. While its enable bit is set, the counter advances by one per clock. When it reaches the reload value it wraps to zero, and that cycle is the update event. In repetitive mode the timer keeps running across update events. In single-pulse mode the update event clears the enable bit and leaves the counter at zero, so each start produces exactly one period.

A single-pulse period can be started by a rising edge on the trigger input or by a software write of 1 to the enable bit. Software can also write the enable bit to 0. That stops the counter and keeps its value, which is different from the hardware stop at the update event, where the counter is left at zero. The compare channel produces an output reference level in one of four modes. An optional fast-compare path sets the output to its post-match level as soon as a trigger starts the timer, instead of waiting for the counter to reach the compare value.

Top module: `pulse_timer`

## Requirements
- R1: After reset, en_o = 0, cnt_o = 0 and oref_o = 0.
- R2: While en_o = 1 and no software stop is written, cnt_o rises by one each cycle. In the cycle after cnt_o equals reload_i, cnt_o is 0; that cycle with cnt_o = reload_i is the update event.
- R3: With one_shot_i = 0, en_o stays 1 across update events until software writes 0.
- R4: With one_shot_i = 1, an update event with no software write in the same cycle clears en_o, and cnt_o stays at 0 afterwards.
- R5: With one_shot_i = 1 and en_o = 0, a trig_i rising edge (0 in the previous cycle, 1 now) sets en_o in the next cycle.
- R6: A write (en_wr_i = 1) loads en_wdata_i into en_o in the next cycle and takes priority over triggers and update events. A written 0 freezes cnt_o at its value in the write cycle.
- R7: Trigger edges have no effect while en_o = 1 or while one_shot_i = 0. The counter then neither restarts nor starts.
- R8: mode_i selects the output. Code 0: oref_o = 1 while the count is below cmp_i. Code 1: the inverse of code 0. Code 2: constant 0. Code 3: constant 1. oref_o is a registered function of the count and mode of the previous cycle, so it changes one cycle after the count meets cmp_i.
- R9: If fast_en_i = 1, mode_i is 0 or 1, and a trigger edge starts the timer, oref_o shows the post-match level (0 for code 0, 1 for code 1) from the cycle en_o rises until en_o clears.
- R10: fast_en_i has no effect on a software start or in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger input, rising edge active |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| one_shot_i | input | 1 | 1 = single-pulse mode, 0 = repetitive |
| mode_i | input | 2 | Output mode code (see R8) |
| fast_en_i | input | 1 | Fast-compare enable |
| cmp_i | input | W | Compare value |
| reload_i | input | W | Reload (wrap) value |
| en_o | output | 1 | Enable bit readback |
| cnt_o | output | W | Counter readback |
| oref_o | output | 1 | Output reference level |

## Verification
A stuck or wrongly set enable bit shows on en_o in the next cycle. It also shows within one reload period as a counter that runs on past a single-pulse update event, or stalls after a software start. A fast-compare flag left armed after the timer stops shows on oref_o one cycle after the stop, because the idle level must follow the count again. A wrong wrap or hold shows on cnt_o in the next cycle. A compare latency that is off by one shows on oref_o at the first count that equals cmp_i.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  typedef enum logic [1:0] {
    OM_HI_FIRST = 2'd0,
    OM_LO_FIRST = 2'd1,
    OM_FORCE_LO = 2'd2,
    OM_FORCE_HI = 2'd3
  } omode_e;

  function automatic logic is_pwm(input omode_e m);
    return (m == OM_HI_FIRST) || (m == OM_LO_FIRST);
  endfunction
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl #(
  parameter bit HAS_FAST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic one_shot_i,
  input  logic fast_req_i,
  input  logic upd_i,
  output logic en_o,
  output logic sw_clr_o,
  output logic fast_nx_o
);
  logic trig_q, en_q, en_d, rise, start_trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      trig_q <= trig_i;
      en_q   <= en_d;
    end
  end

  assign rise       = trig_i & ~trig_q;
  assign start_trig = one_shot_i & rise & ~en_q;
  assign sw_clr_o   = en_wr_i & ~en_wdata_i;

  // software write wins, then trigger start, then single-pulse stop
  always_comb begin
    en_d = en_q;
    if (en_wr_i)                  en_d = en_wdata_i;
    else if (start_trig)          en_d = 1'b1;
    else if (upd_i && one_shot_i) en_d = 1'b0;
  end

  generate
    if (HAS_FAST) begin : g_fast
      logic fast_q, fast_d;
      assign fast_d = en_d & ((start_trig & ~en_wr_i & fast_req_i) | fast_q);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fast_q <= 1'b0;
        else         fast_q <= fast_d;
      end
      assign fast_nx_o = fast_d;
    end else begin : g_nofast
      logic unused_fast;
      assign unused_fast = fast_req_i;
      assign fast_nx_o   = 1'b0;
    end
  endgenerate

  assign en_o = en_q;
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         hold_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         upd_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;
  logic         run;

  assign run   = en_i & ~hold_i;
  assign upd_o = run & (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (upd_o) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pt_compare.sv
module pt_compare
  import pulse_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  omode_e       mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         fast_nx_i,
  output logic         oref_o
);
  logic below, oref_d, oref_q;

  assign below = cnt_i < cmp_i;

  always_comb begin
    unique case (mode_i)
      OM_HI_FIRST: oref_d = fast_nx_i ? 1'b0 : below;
      OM_LO_FIRST: oref_d = fast_nx_i ? 1'b1 : ~below;
      OM_FORCE_LO: oref_d = 1'b0;
      default:     oref_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oref_q <= 1'b0;
    else         oref_q <= oref_d;
  end

  assign oref_o = oref_q;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int W        = 16,
  parameter bit HAS_FAST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_i,
  input  logic         en_wr_i,
  input  logic         en_wdata_i,
  input  logic         one_shot_i,
  input  logic [1:0]   mode_i,
  input  logic         fast_en_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] reload_i,
  output logic         en_o,
  output logic [W-1:0] cnt_o,
  output logic         oref_o
);
  omode_e mode;
  logic   en, sw_clr, upd, fast_nx, fast_req;

  assign mode     = omode_e'(mode_i);
  assign fast_req = fast_en_i & is_pwm(mode);

  pt_ctrl #(.HAS_FAST(HAS_FAST)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .one_shot_i(one_shot_i),
    .fast_req_i(fast_req), .upd_i(upd),
    .en_o(en), .sw_clr_o(sw_clr), .fast_nx_o(fast_nx)
  );

  pt_counter #(.W(W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .hold_i(sw_clr),
    .reload_i(reload_i), .cnt_o(cnt_o), .upd_o(upd)
  );

  pt_compare #(.W(W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .cnt_i(cnt_o),
    .cmp_i(cmp_i), .fast_nx_i(fast_nx), .oref_o(oref_o)
  );

  assign en_o = en;
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         trig_i,
  input logic         en_wr_i,
  input logic         en_wdata_i,
  input logic         one_shot_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] reload_i,
  input logic         en_o,
  input logic [W-1:0] cnt_o,
  input logic         oref_o
);
  localparam logic [W-1:0] ONE = W'(1);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && !en_wr_i && cnt_o != reload_i |=> cnt_o == $past(cnt_o) + ONE);

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && !en_wr_i && cnt_o == reload_i |=> cnt_o == '0);

  assert_repeat_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !one_shot_i && en_o && !en_wr_i |=> en_o);

  assert_single_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_shot_i && en_o && !en_wr_i && cnt_o == reload_i |=> !en_o && cnt_o == '0);

  assert_trig_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_shot_i && !en_o && !en_wr_i && trig_i && !$past(trig_i) |=> en_o);

  assert_sw_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && !en_wdata_i |=> !en_o && cnt_o == $past(cnt_o));

  assert_sw_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i && en_wdata_i |=> en_o);

  assert_idle_no_trig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !one_shot_i && !en_o && !en_wr_i |=> !en_o && $stable(cnt_o));

  assert_force_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |=> oref_o);

  assert_force_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |=> !oref_o);
endmodule

bind pulse_timer pt_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .en_wr_i(en_wr_i),
  .en_wdata_i(en_wdata_i), .one_shot_i(one_shot_i), .mode_i(mode_i),
  .reload_i(reload_i), .en_o(en_o), .cnt_o(cnt_o), .oref_o(oref_o)
);

// File: tb/tb_pulse_timer.sv
module tb_pulse_timer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 0, wr = 0, wd = 0, os = 0, fe = 0;
  logic [1:0] mode = 0;
  logic [W-1:0] cmp = 0, rel = 0;
  logic en_o, oref_o;
  logic [W-1:0] cnt_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic m_en = 0, m_fast = 0, m_trq = 0, m_oref = 0;
  logic [W-1:0] m_cnt = 0;

  always #4 clk = ~clk;

  pulse_timer #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .en_wr_i(wr), .en_wdata_i(wd),
    .one_shot_i(os), .mode_i(mode), .fast_en_i(fe), .cmp_i(cmp), .reload_i(rel),
    .en_o(en_o), .cnt_o(cnt_o), .oref_o(oref_o)
  );

  function automatic logic ref_level(input logic [1:0] md, input logic fst,
                                     input logic [W-1:0] c, input logic [W-1:0] k);
    logic pwm = (md < 2);
    if (pwm && fst) return md == 2'd1;
    case (md)
      2'd0: return c < k;
      2'd1: return !(c < k);
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_step();
    logic rise, clr, upd, st, en_n, sf, fast_n;
    rise  = trig & ~m_trq;
    clr   = wr & ~wd;
    upd   = m_en & ~clr & (m_cnt == rel);
    st    = os & rise & ~m_en;
    en_n  = wr ? wd : st ? 1'b1 : (upd & os) ? 1'b0 : m_en;
    sf    = st & ~wr & fe & (mode < 2);
    fast_n = en_n & (sf | m_fast);
    m_oref = ref_level(mode, fast_n, m_cnt, cmp);
    if (m_en && !clr) m_cnt = upd ? '0 : m_cnt + 1'b1;
    m_en = en_n; m_fast = fast_n; m_trq = trig;
  endtask

  task automatic compare(input string tag);
    checks += 3;
    if (en_o !== m_en) begin
      fails++; $display("FAIL %s en_o actual=%0b expected=%0b t=%0t", tag, en_o, m_en, $time);
    end
    if (cnt_o !== m_cnt) begin
      fails++; $display("FAIL %s cnt_o actual=%0d expected=%0d t=%0t", tag, cnt_o, m_cnt, $time);
    end
    if (oref_o !== m_oref) begin
      fails++; $display("FAIL %s oref_o actual=%0b expected=%0b t=%0t", tag, oref_o, m_oref, $time);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic sw_write(input logic v, input string tag);
    wr = 1; wd = v; cyc(tag); wr = 0; wd = 0;
  endtask

  task automatic trig_pulse(input string tag);
    trig = 1; cyc(tag); trig = 0; cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset");

    // repetitive run, PWM code 0
    rel = 5; cmp = 3; mode = 0; os = 0;
    sw_write(1, "R6 sw start");
    run(20, "R2 R3 R8 repetitive");
    sw_write(0, "R6 sw stop hold");
    run(3, "R6 held");
    trig_pulse("R7 trig outside single-pulse");
    run(2, "R7 idle");

    // single-pulse via software, from held count to wrap
    os = 1; mode = 1;
    sw_write(1, "R6 sw start single");
    run(10, "R4 single-pulse stop");
    run(3, "R4 stays idle");

    // trigger start with fast compare, code 1
    rel = 10; cmp = 6; fe = 1;
    trig_pulse("R5 R9 trig fast start");
    run(2, "R9 fast level");
    trig_pulse("R7 trig while running");
    run(12, "R4 R9 after stop");

    // fast with code 0
    mode = 0;
    trig_pulse("R9 fast code 0");
    run(12, "R9 code 0 pulse");

    // fast ignored on software start and in forced modes
    sw_write(1, "R10 sw start fast ignored");
    run(12, "R10 sw start");
    mode = 2;
    trig_pulse("R10 forced low");
    run(12, "R8 R10 forced low");
    mode = 3;
    trig_pulse("R10 forced high");
    run(12, "R8 R10 forced high");
    fe = 0;

    // random mix
    rel = 15;
    for (int i = 0; i < 4000; i++) begin
      trig = ($urandom % 4) == 0;
      wr   = ($urandom % 40) == 0;
      wd   = $urandom % 2;
      if (($urandom % 64) == 0) os = $urandom % 2;
      if (($urandom % 32) == 0) mode = 2'($urandom % 4);
      if (($urandom % 16) == 0) fe = $urandom % 2;
      if (($urandom % 16) == 0) cmp = W'($urandom % 17);
      cyc("R2 R3 R4 R5 R7 R8 R9 random");
    end
    wr = 0; trig = 0;
    run(4, "R2 tail");
    finish_run();
  end
endmodule